// File: doc/BRIEF.md
# Two-Channel Compare Waveform Generator

This block turns the running value of a 16-bit timer into two waveform pins. Each channel holds a compare value and a 2-bit output code. When the counter reaches the compare value, or the timer reaches its upper limit, the channel sets, clears or toggles its pin. What a code means depends on the counting scheme in force: plain counting, single-slope PWM, or up/down (phase-correct) PWM. The counter, the choice of limit and the mode decoding are outside the block. It receives the counter value, the direction, a strobe that marks the limit, a 2-bit counting-class input, and a flag that says whether channel A's compare value is the limit.

Each pin has its own output enable. The enable is high whenever the pin's effective setting drives the pin. Each channel also raises a one-clock flag when the counter meets its compare value. A force strobe for each channel applies that channel's action without a real match, but only while plain counting is selected.

Top module: `ocu_wavegen`

## Requirements
- R1: After reset both waveform outputs, both output enables and both match flags are 0.
- R2: Output code 00 deasserts that channel's output enable on the next clock and leaves its waveform register unchanged, in every counting class.
- R3: With class 0 (plain counting) or the unused class 3, a compare match applies the channel's code on the next clock: 01 toggles, 10 clears and 11 sets the waveform, and the output enable is 1.
- R4: A match flag is a one-clock pulse on the clock after the counter equals that channel's compare value, in every class. A force strobe never sets it.
- R5: In class 1 (single-slope PWM), code 10 clears on a match and sets when the limit strobe is high. Code 11 clears when the limit strobe is high and sets on a match.
- R6: In class 1 with code 10 or 11, a match in the same cycle as the limit strobe is ignored, and only the limit action takes effect.
- R7: In class 2 (phase-correct PWM), with direction input 0 for counting up and 1 for counting down, code 10 clears on an up-count match and sets on a down-count match. Code 11 does the opposite.
- R8: In classes 1 and 2, code 01 toggles channel A on a match and enables its output only when the limit flag is 1. Otherwise channel A is disabled and held. Channel B with code 01 is always disabled and held.
- R9: In classes 0 and 3, a force strobe applies the channel's current code as if a match occurred. A coincident real match still gives a single action.
- R10: In classes 1 and 2, a force strobe has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Current timer count |
| cnt_down_i | input | 1 | 1 while counting down |
| top_hit_i | input | 1 | Count is at its limit this cycle |
| mode_i | input | 2 | Counting class: 0 plain, 1 single-slope PWM, 2 phase-correct PWM |
| top_from_a_i | input | 1 | Channel A compare value is the limit |
| com_a_i | input | 2 | Output code for channel A |
| com_b_i | input | 2 | Output code for channel B |
| cmp_a_i | input | 16 | Compare value for channel A |
| cmp_b_i | input | 16 | Compare value for channel B |
| force_a_i | input | 1 | Force strobe for channel A |
| force_b_i | input | 1 | Force strobe for channel B |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| oe_a_o | output | 1 | Channel A output enable |
| oe_b_o | output | 1 | Channel B output enable |
| match_a_o | output | 1 | Channel A match flag |
| match_b_o | output | 1 | Channel B match flag |

## Verification
Each counting class is driven with real matches on one channel at a time. This shows that every code moves only its own pin and in the expected direction. Limit strobes alone, and a limit strobe together with a match, separate the limit action from the match action in single-slope PWM. Up and down matches in phase-correct mode show that the direction selects the action. Force strobes are applied in every class, and code 01 is tried with the limit flag both high and low. Together these separate plain-mode behaviour from PWM behaviour and channel A from channel B.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    typedef enum logic [1:0] {
        MC_PLAIN = 2'd0,
        MC_FAST  = 2'd1,
        MC_PHASE = 2'd2,
        MC_RSVD  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_SET  = 2'd2,
        ACT_TOG  = 2'd3
    } act_e;

    typedef struct packed {
        logic wave;
        logic oe;
        logic flag;
    } chan_st_t;
endpackage

// File: rtl/ocu_action_dec.sv
module ocu_action_dec
    import ocu_pkg::*;
(
    input  mode_e      mode_i,
    input  logic [1:0] com_i,
    input  logic       tog_ok_i,
    input  logic       match_i,
    input  logic       top_hit_i,
    input  logic       down_i,
    input  logic       force_i,
    output act_e       act_o,
    output logic       drive_o
);
    logic event_plain;

    always_comb begin
        event_plain = match_i | force_i;
        act_o       = ACT_HOLD;
        drive_o     = 1'b0;
        unique case (mode_i)
            MC_FAST: begin
                unique case (com_i)
                    2'b01: begin
                        drive_o = tog_ok_i;
                        if (tog_ok_i && match_i) act_o = ACT_TOG;
                    end
                    2'b10: begin
                        drive_o = 1'b1;
                        if (top_hit_i)    act_o = ACT_SET;
                        else if (match_i) act_o = ACT_CLR;
                    end
                    2'b11: begin
                        drive_o = 1'b1;
                        if (top_hit_i)    act_o = ACT_CLR;
                        else if (match_i) act_o = ACT_SET;
                    end
                    default: ;
                endcase
            end
            MC_PHASE: begin
                unique case (com_i)
                    2'b01: begin
                        drive_o = tog_ok_i;
                        if (tog_ok_i && match_i) act_o = ACT_TOG;
                    end
                    2'b10: begin
                        drive_o = 1'b1;
                        if (match_i) act_o = down_i ? ACT_SET : ACT_CLR;
                    end
                    2'b11: begin
                        drive_o = 1'b1;
                        if (match_i) act_o = down_i ? ACT_CLR : ACT_SET;
                    end
                    default: ;
                endcase
            end
            default: begin
                unique case (com_i)
                    2'b01: begin
                        drive_o = 1'b1;
                        if (event_plain) act_o = ACT_TOG;
                    end
                    2'b10: begin
                        drive_o = 1'b1;
                        if (event_plain) act_o = ACT_CLR;
                    end
                    2'b11: begin
                        drive_o = 1'b1;
                        if (event_plain) act_o = ACT_SET;
                    end
                    default: ;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
    import ocu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter bit IS_A  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode_i,
    input  logic             top_from_a_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic             top_hit_i,
    input  logic [1:0]       com_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             force_i,
    output logic             wave_o,
    output logic             oe_o,
    output logic             match_o
);
    chan_st_t st_d, st_q;
    act_e     act;
    logic     drive;
    logic     hit;
    logic     tog_ok;

    assign hit    = (cnt_i == cmp_i);
    assign tog_ok = IS_A && top_from_a_i;

    ocu_action_dec dec_i (
        .mode_i    (mode_i),
        .com_i     (com_i),
        .tog_ok_i  (tog_ok),
        .match_i   (hit),
        .top_hit_i (top_hit_i),
        .down_i    (cnt_down_i),
        .force_i   (force_i),
        .act_o     (act),
        .drive_o   (drive)
    );

    always_comb begin
        st_d      = st_q;
        st_d.flag = hit;
        st_d.oe   = drive;
        unique case (act)
            ACT_CLR: st_d.wave = 1'b0;
            ACT_SET: st_d.wave = 1'b1;
            ACT_TOG: st_d.wave = ~st_q.wave;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave_o  = st_q.wave;
    assign oe_o    = st_q.oe;
    assign match_o = st_q.flag;

    p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        com_i == 2'b00 |=> !oe_o && $stable(wave_o));

    p_plain_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MC_PLAIN) && com_i == 2'b10 && cnt_i == cmp_i |=> !wave_o);

    p_force_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_i && cnt_i != cmp_i |=> !match_o);

    p_fast_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MC_FAST) && com_i[1] && top_hit_i |=> wave_o == !$past(com_i[0]));

    p_phase_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MC_PHASE) && com_i[1] && cnt_i == cmp_i
        |=> wave_o == ($past(cnt_down_i) ^ $past(com_i[0])));

    p_pwm_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MC_FAST || mode_i == MC_PHASE) && force_i
        && cnt_i != cmp_i && !top_hit_i |=> $stable(wave_o));

    generate
        if (!IS_A) begin : g_b_checks
            p_b_no_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == MC_FAST || mode_i == MC_PHASE) && com_i == 2'b01
                |=> !oe_o && $stable(wave_o));
        end
    endgenerate
endmodule

// File: rtl/ocu_wavegen.sv
module ocu_wavegen
    import ocu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic             top_hit_i,
    input  logic [1:0]       mode_i,
    input  logic             top_from_a_i,
    input  logic [1:0]       com_a_i,
    input  logic [1:0]       com_b_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  logic             force_a_i,
    input  logic             force_b_i,
    output logic             wave_a_o,
    output logic             wave_b_o,
    output logic             oe_a_o,
    output logic             oe_b_o,
    output logic             match_a_o,
    output logic             match_b_o
);
    localparam int NCH = 2;

    mode_e            mode;
    logic [1:0]       com   [NCH];
    logic [CNT_W-1:0] cmp   [NCH];
    logic             frc   [NCH];
    logic             wave  [NCH];
    logic             oe    [NCH];
    logic             flag  [NCH];

    assign mode   = mode_e'(mode_i);
    assign com[0] = com_a_i;
    assign com[1] = com_b_i;
    assign cmp[0] = cmp_a_i;
    assign cmp[1] = cmp_b_i;
    assign frc[0] = force_a_i;
    assign frc[1] = force_b_i;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            ocu_channel #(
                .CNT_W (CNT_W),
                .IS_A  (c == 0)
            ) ch_i (
                .clk          (clk),
                .rst_n        (rst_n),
                .mode_i       (mode),
                .top_from_a_i (top_from_a_i),
                .cnt_i        (cnt_i),
                .cnt_down_i   (cnt_down_i),
                .top_hit_i    (top_hit_i),
                .com_i        (com[c]),
                .cmp_i        (cmp[c]),
                .force_i      (frc[c]),
                .wave_o       (wave[c]),
                .oe_o         (oe[c]),
                .match_o      (flag[c])
            );
        end
    endgenerate

    assign wave_a_o  = wave[0];
    assign wave_b_o  = wave[1];
    assign oe_a_o    = oe[0];
    assign oe_b_o    = oe[1];
    assign match_a_o = flag[0];
    assign match_b_o = flag[1];
endmodule

// File: tb/ocu_wavegen_tb_top.sv
module ocu_wavegen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'd50;
    logic        down = 1'b0, top = 1'b0, topa = 1'b0;
    logic [1:0]  mode = 2'd0, ca = 2'd0, cb = 2'd0;
    logic [15:0] cmpa = 16'd100, cmpb = 16'd200;
    logic        fa = 1'b0, fb = 1'b0;
    logic        wa, wb, oea, oeb, mfa, mfb;
    int          checks = 0, fails = 0;

    always #10 clk = ~clk;

    ocu_wavegen dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_down_i(down), .top_hit_i(top),
        .mode_i(mode), .top_from_a_i(topa), .com_a_i(ca), .com_b_i(cb),
        .cmp_a_i(cmpa), .cmp_b_i(cmpb), .force_a_i(fa), .force_b_i(fb),
        .wave_a_o(wa), .wave_b_o(wb), .oe_a_o(oea), .oe_b_o(oeb),
        .match_a_o(mfa), .match_b_o(mfb)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       topa, down, top;
        logic [1:0] ca, cb;
        logic       ma, mb, fa, fb;
        logic [5:0] exp;  // {wa, wb, oea, oeb, flag_a, flag_b}
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b0,1'b0,1'b0,2'd1,2'd3,1'b1,1'b0,1'b0,1'b0,6'b10_11_10}, // R3 toggle A, R4 flag
        '{2'd0,1'b0,1'b0,1'b0,2'd1,2'd3,1'b0,1'b1,1'b0,1'b0,6'b11_11_01}, // R3 set B
        '{2'd0,1'b0,1'b0,1'b0,2'd2,2'd2,1'b1,1'b0,1'b0,1'b0,6'b01_11_10}, // R3 clear A
        '{2'd0,1'b0,1'b0,1'b0,2'd3,2'd2,1'b0,1'b0,1'b1,1'b1,6'b10_11_00}, // R9 force, R4 no flag
        '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b1,1'b1,6'b10_00_00}, // R2 disconnected
        '{2'd1,1'b0,1'b0,1'b1,2'd2,2'd3,1'b0,1'b0,1'b0,1'b0,6'b10_11_00}, // R5 TOP actions
        '{2'd1,1'b0,1'b0,1'b0,2'd2,2'd3,1'b1,1'b0,1'b0,1'b0,6'b00_11_10}, // R5 clear on match
        '{2'd1,1'b0,1'b0,1'b0,2'd2,2'd3,1'b0,1'b1,1'b0,1'b0,6'b01_11_01}, // R5 set on match
        '{2'd1,1'b0,1'b0,1'b1,2'd2,2'd3,1'b1,1'b0,1'b0,1'b0,6'b10_11_10}, // R6 match at TOP ignored
        '{2'd1,1'b0,1'b0,1'b0,2'd2,2'd3,1'b0,1'b0,1'b1,1'b1,6'b10_11_00}, // R10 force ignored
        '{2'd1,1'b0,1'b0,1'b0,2'd1,2'd1,1'b1,1'b0,1'b0,1'b0,6'b10_00_10}, // R8 no toggle
        '{2'd1,1'b1,1'b0,1'b0,2'd1,2'd1,1'b1,1'b0,1'b0,1'b0,6'b00_10_10}, // R8 toggle A only
        '{2'd2,1'b0,1'b1,1'b0,2'd2,2'd3,1'b1,1'b0,1'b0,1'b0,6'b10_11_10}, // R7 down sets
        '{2'd2,1'b0,1'b0,1'b0,2'd2,2'd3,1'b1,1'b0,1'b0,1'b0,6'b00_11_10}, // R7 up clears
        '{2'd2,1'b0,1'b0,1'b0,2'd2,2'd3,1'b0,1'b1,1'b0,1'b0,6'b01_11_01}, // R7 code 11 up sets
        '{2'd2,1'b0,1'b1,1'b0,2'd2,2'd3,1'b0,1'b1,1'b0,1'b0,6'b00_11_01}, // R7 code 11 down clears
        '{2'd2,1'b1,1'b0,1'b0,2'd1,2'd1,1'b1,1'b0,1'b0,1'b0,6'b10_10_10}, // R8 toggle A
        '{2'd2,1'b1,1'b0,1'b0,2'd1,2'd1,1'b0,1'b1,1'b0,1'b0,6'b10_10_01}, // R8 B disconnected
        '{2'd2,1'b0,1'b0,1'b0,2'd3,2'd2,1'b0,1'b0,1'b1,1'b1,6'b10_11_00}  // R10 force ignored
    };

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {wa, wb, oea, oeb, mfa, mfb};
    endfunction

    initial begin
        @(negedge clk);
        check("R1 reset", outs(), 6'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            mode = VECS[i].mode; topa = VECS[i].topa; down = VECS[i].down;
            top  = VECS[i].top;  ca = VECS[i].ca;     cb = VECS[i].cb;
            fa   = VECS[i].fa;   fb = VECS[i].fb;
            cnt  = VECS[i].ma ? cmpa : (VECS[i].mb ? cmpb : 16'd50);
            @(posedge clk);
            @(negedge clk);
            fa = 1'b0; fb = 1'b0; top = 1'b0; cnt = 16'd50;
            check($sformatf("vector %0d", i), outs(), VECS[i].exp);
        end
        // R4: flag lasts a single clock
        @(posedge clk); @(negedge clk);
        check("R4 flag pulse width", {mfa, mfb}, 2'b00);
        // R9: force together with real match toggles once
        mode = 2'd0; ca = 2'd1; cb = 2'd0; cnt = cmpa; fa = 1'b1;
        @(posedge clk); @(negedge clk);
        fa = 1'b0; cnt = 16'd50;
        check("R9 force+match single toggle", {wa, oea, mfa}, 3'b011);
        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", outs(), 6'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule